// File: doc/BRIEF.md
# Streaming Video Component-Inversion Stage

This block sits on a packetized video stream between an upstream source and a downstream sink. Both sides use a five-signal handshake (ready, valid, data, start-of-packet, end-of-packet). Ready acts with a latency of one cycle: ready high in one cycle permits exactly one beat in the following cycle. The block drives ready on its input and obeys the same rule on its output, where it presents a beat only in a cycle that follows a cycle with downstream ready high.

The first beat of every packet is a type beat whose low four bits hold the packet type. That beat passes through unchanged. In a packet of type 0 (video), every later beat carries one pixel of three 8-bit components. The block replaces each component v by 255 - v. Beats of packets with any other type pass through untouched. The work runs through a three-stage pipeline, which gives three cycles of latency when nothing stalls. A small skid store at the output absorbs beats that are still in flight after downstream drops ready. While that store holds anything, input ready stays low.

Top module: `vid_invert_stage`

## Requirements
- R1: While rst_n is low, in_ready and out_valid are low. Within three cycles after rst_n goes high, in_ready is high when no backpressure has occurred.
- R2: An input beat is taken only in a cycle with in_valid high whose preceding cycle had in_ready high. A beat offered while in_ready was low in the preceding cycle is ignored and never reaches the output. A cycle with in_valid low is simply idle.
- R3: out_valid is high only in a cycle whose preceding cycle had out_ready high, and every cycle with out_valid high delivers one beat.
- R4: With out_ready held high, a beat taken in cycle N appears on the output in cycle N+3.
- R5: A beat with in_sop high (the type beat) is output with all 24 data bits unchanged and out_sop high. Its type is in_data[3:0].
- R6: In a packet whose type is 0, every beat after the type beat up to and including the in_eop beat is output with each 8-bit component (bits 23:16, 15:8, 7:0) replaced by 255 minus its value.
- R7: In a packet with a non-zero type, every beat is output unchanged.
- R8: Each beat keeps its own start-of-packet and end-of-packet flags, and beats leave in the order they arrived.
- R9: Under any pattern of out_ready no beat is lost or duplicated. The skid store of SKID_DEPTH entries (at least 4) never overflows, and input ready is low whenever the store holds a beat.
- R10: A beat taken after an end-of-packet beat and before the next start-of-packet beat passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_ready | output | 1 | Block can take a beat in the next cycle |
| in_valid | input | 1 | Upstream beat present |
| in_data | input | 24 | Upstream beat data |
| in_sop | input | 1 | Upstream beat starts a packet |
| in_eop | input | 1 | Upstream beat ends a packet |
| out_ready | input | 1 | Downstream can take a beat in the next cycle |
| out_valid | output | 1 | Output beat present (always a transfer) |
| out_data | output | 24 | Output beat data |
| out_sop | output | 1 | Output beat starts a packet |
| out_eop | output | 1 | Output beat ends a packet |

## Verification
The assertions check the handshake on every cycle. They cover the quiet state during reset, output valid appearing only one cycle after downstream ready, the skid store staying within its depth, and input being blocked while the store is occupied. The bench scenarios are needed for the data path: correct inversion of video pixels, untouched type beats, non-video packets and stray beats, the exact three-cycle latency, ignored offers made without ready, and complete in-order delivery through long downstream stalls.

// File: rtl/vid_pkg.sv
// Package: shared widths and the beat record used by the inversion stage.
// Assumes three components per pixel and a 4-bit type field in the type beat.
package vid_pkg;
    localparam int COMP_W = 8;
    localparam int N_COMP = 3;
    localparam int DATA_W = COMP_W * N_COMP;
    localparam int TYPE_W = 4;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [DATA_W-1:0] data;
    } beat_t;
endpackage

// File: rtl/vid_ingress.sv
// Ingress stage: drives input ready, applies the one-cycle ready latency
// to decide which offered beats are taken, tracks whether the open packet
// is video, and registers each taken beat with a flag telling the next
// stage whether to invert it. Assumes skid_empty comes from the output store.
module vid_ingress
    import vid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              skid_empty,
    output logic              in_ready,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              s1_valid,
    output beat_t             s1_beat,
    output logic              s1_inv
);
    logic run_q;
    logic rdy_d;
    logic video_q;
    logic video_n;
    logic inv_n;
    logic take;

    // Input ready: up after reset, and only while the skid store is empty.
    assign in_ready = run_q & skid_empty;

    // A beat is taken when valid follows a cycle with ready high.
    assign take = in_valid & rdy_d;

    // Packet classification for the beat being taken.
    always_comb begin
        video_n = video_q;
        inv_n   = 1'b0;
        if (in_sop) begin
            video_n = (in_data[TYPE_W-1:0] == '0);
        end else begin
            inv_n = video_q;
        end
        if (in_eop) begin
            video_n = 1'b0;
        end
    end

    // Control registers: run flag, delayed ready and packet state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            rdy_d    <= 1'b0;
            video_q  <= 1'b0;
            s1_valid <= 1'b0;
        end else begin
            run_q    <= 1'b1;
            rdy_d    <= in_ready;
            s1_valid <= take;
            if (take) begin
                video_q <= video_n;
            end
        end
    end

    // Stage-one data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_beat <= '0;
            s1_inv  <= 1'b0;
        end else if (take) begin
            s1_beat.sop  <= in_sop;
            s1_beat.eop  <= in_eop;
            s1_beat.data <= in_data;
            s1_inv       <= inv_n;
        end
    end
endmodule

// File: rtl/vid_pixel_op.sv
// Pixel stage: inverts every component of a flagged beat and registers
// the result. Assumes an unsigned component, so max-minus-value is the
// bitwise complement.
module vid_pixel_op
    import vid_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  s1_valid,
    input  beat_t s1_beat,
    input  logic  s1_inv,
    output logic  s2_valid,
    output beat_t s2_beat
);
    logic [DATA_W-1:0] op_data;

    // One inverter per component.
    for (genvar c = 0; c < N_COMP; c++) begin : g_comp
        assign op_data[c*COMP_W +: COMP_W] = s1_inv ? ~s1_beat.data[c*COMP_W +: COMP_W]
                                                    :  s1_beat.data[c*COMP_W +: COMP_W];
    end

    // Stage-two register; it never stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_beat  <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_beat.sop  <= s1_beat.sop;
                s2_beat.eop  <= s1_beat.eop;
                s2_beat.data <= op_data;
            end
        end
    end
endmodule

// File: rtl/vid_skid_out.sv
// Output stage: a registered output that presents a beat only after a
// cycle with downstream ready, plus a skid store for beats that arrive
// while the output is blocked. Assumes DEPTH >= 4, which covers the two
// pipeline stages plus the two beats a one-cycle ready latency lets through.
module vid_skid_out
    import vid_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s2_valid,
    input  beat_t            s2_beat,
    input  logic             out_ready,
    output logic             out_valid,
    output beat_t            out_beat,
    output logic [CNT_W-1:0] skid_cnt,
    output logic             skid_empty
);
    beat_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_q;
    logic [PTR_W-1:0] rd_q;
    logic             have;
    logic             pop;
    logic             take_s2;
    logic             push;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign have       = (skid_cnt != '0);
    assign skid_empty = !have;
    assign pop        = out_ready & have;
    assign take_s2    = out_ready & !have & s2_valid;
    assign push       = s2_valid & !take_s2;

    // Skid storage write.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_q] <= s2_beat;
        end
    end

    // Skid pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= '0;
            rd_q     <= '0;
            skid_cnt <= '0;
        end else begin
            if (push) wr_q <= ptr_inc(wr_q);
            if (pop)  rd_q <= ptr_inc(rd_q);
            skid_cnt <= skid_cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Output register: oldest beat first, skid ahead of the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_beat  <= '0;
        end else begin
            out_valid <= out_ready & (have | s2_valid);
            if (pop) begin
                out_beat <= mem[rd_q];
            end else if (take_s2) begin
                out_beat <= s2_beat;
            end
        end
    end
endmodule

// File: rtl/vid_invert_stage.sv
// Top: three-stage component-inversion stage on a packetized video
// stream with one-cycle ready latency on both ports. Stage one takes and
// classifies beats, stage two inverts, stage three is the output register
// backed by a skid store. Assumes SKID_DEPTH >= 4.
module vid_invert_stage
    import vid_pkg::*;
#(
    parameter int SKID_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              in_ready,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop
);
    localparam int SKID_CNT_W = $clog2(SKID_DEPTH + 1);

    logic                  skid_empty;
    logic [SKID_CNT_W-1:0] skid_cnt;
    logic                  s1_valid;
    beat_t                 s1_beat;
    logic                  s1_inv;
    logic                  s2_valid;
    beat_t                 s2_beat;
    beat_t                 out_beat;

    vid_ingress u_ingress (
        .clk        (clk),
        .rst_n      (rst_n),
        .skid_empty (skid_empty),
        .in_ready   (in_ready),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .s1_valid   (s1_valid),
        .s1_beat    (s1_beat),
        .s1_inv     (s1_inv)
    );

    vid_pixel_op u_pixel (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_valid (s1_valid),
        .s1_beat  (s1_beat),
        .s1_inv   (s1_inv),
        .s2_valid (s2_valid),
        .s2_beat  (s2_beat)
    );

    vid_skid_out #(.DEPTH(SKID_DEPTH)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .s2_valid   (s2_valid),
        .s2_beat    (s2_beat),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_beat   (out_beat),
        .skid_cnt   (skid_cnt),
        .skid_empty (skid_empty)
    );

    assign out_data = out_beat.data;
    assign out_sop  = out_beat.sop;
    assign out_eop  = out_beat.eop;
endmodule

// File: rtl/vid_invert_stage_chk.sv
// Checker: handshake and skid-store properties of the inversion stage,
// bound into every instance of the top module.
module vid_invert_stage_chk #(
    parameter int SKID_DEPTH = 4,
    parameter int CNT_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             in_valid,
    input logic             out_ready,
    input logic             out_valid,
    input logic [CNT_W-1:0] skid_cnt
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!in_ready && !out_valid)); // R1

    AST_OUT_READY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(out_ready)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        skid_cnt <= CNT_W'(SKID_DEPTH)); // R9

    AST_SKID_HOLDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (skid_cnt != '0) |=> !(in_valid && $past(in_ready))); // R9
endmodule

bind vid_invert_stage vid_invert_stage_chk #(
    .SKID_DEPTH (SKID_DEPTH),
    .CNT_W      (SKID_CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .skid_cnt  (skid_cnt)
);

// File: tb/vid_invert_stage_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model (queues of expected beats) compared
// on every clock. Inputs change 1 ns after the rising edge; all sampling
// happens on the falling edge.
module vid_invert_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_ready;
    logic        in_valid;
    logic [23:0] in_data;
    logic        in_sop;
    logic        in_eop;
    logic        out_ready;
    logic        out_valid;
    logic [23:0] out_data;
    logic        out_sop;
    logic        out_eop;

    always #2.5 clk = ~clk;

    vid_invert_stage dut_i (
        .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .in_valid(in_valid),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    int          n_checks = 0;
    int          n_errors = 0;
    int          cyc = 0;
    logic [25:0] exp_q[$];
    string       tag_q[$];
    int          tacc_q[$];
    bit          lat_mode = 0;
    bit          gap_mode = 0;
    bit          junk_mode = 0;
    int          ordy_mode = 0;
    bit          prev_in_rdy = 0;
    bit          prev_out_rdy = 0;
    bit          m_video = 0;
    int          stall_len = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Reference model and comparison on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [23:0] e;
            string       t;
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (in_valid && prev_in_rdy) begin
                if (in_sop) begin
                    e = in_data; t = "R5";
                    m_video = (in_data[3:0] == 4'd0);
                end else if (m_video) begin
                    e = {8'd255 - in_data[23:16], 8'd255 - in_data[15:8], 8'd255 - in_data[7:0]};
                    t = "R6";
                end else begin
                    e = in_data; t = "R7/R10";
                end
                if (in_eop) m_video = 0;
                exp_q.push_back({in_sop, in_eop, e});
                tag_q.push_back(t);
                tacc_q.push_back(cyc);
            end
            if (out_valid) begin
                check(prev_out_rdy, "R3", "out_valid without prior out_ready", 32'(out_valid), 0);
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected output beat", {6'd0, out_sop, out_eop, out_data}, 0);
                end else begin
                    logic [25:0] x;
                    string       tg;
                    int          ta;
                    x = exp_q.pop_front(); tg = tag_q.pop_front(); ta = tacc_q.pop_front();
                    check({out_sop, out_eop, out_data} == x, {tg, "/R8"}, "output beat",
                          {6'd0, out_sop, out_eop, out_data}, {6'd0, x});
                    if (lat_mode)
                        check(cyc - ta == 3, "R4", "latency", 32'(cyc - ta), 3);
                end
            end
            if (stall_len >= 6 && tacc_q.size() > 0 && tacc_q[0] <= cyc - 3)
                check(!in_ready, "R9", "in_ready high with skid occupied", 32'(in_ready), 0);
            stall_len    = out_ready ? 0 : stall_len + 1;
            prev_in_rdy  = in_ready;
            prev_out_rdy = out_ready;
        end else begin
            prev_in_rdy  = 0;
            prev_out_rdy = 0;
        end
    end

    // Downstream ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        case (ordy_mode)
            0: out_ready = 1'b1;
            1: out_ready = lfsr[3] | lfsr[7];
            default: out_ready = 1'b0;
        endcase
    end

    task automatic send(input logic [23:0] d, input bit s, input bit e);
        bit r;
        bit sent = 0;
        while (!sent) begin
            @(negedge clk);
            r = in_ready;
            @(posedge clk);
            #1;
            if (r && !(gap_mode && lfsr[0])) begin
                in_valid = 1; in_data = d; in_sop = s; in_eop = e; sent = 1;
            end else begin
                in_valid = junk_mode && !r;
                in_data  = {lfsr[7:0], 16'h5A5A};
                in_sop   = lfsr[1];
                in_eop   = lfsr[2];
            end
        end
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        in_valid = 0; in_sop = 0; in_eop = 0;
    endtask

    task automatic send_packet(input logic [3:0] ty, input int npix, input logic [7:0] seed);
        send({20'd0, ty}, 1, npix == 0);
        for (int i = 0; i < npix; i++) begin
            logic [7:0] a, b, c;
            a = seed + 8'(i);
            b = seed ^ 8'(i * 7);
            c = 8'hF0 - 8'(i);
            send({a, b, c}, 0, i == npix - 1);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 0; in_valid = 0; in_data = '0; in_sop = 0; in_eop = 0; out_ready = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!in_ready && !out_valid, "R1", "quiet during reset",
                  {30'd0, in_ready, out_valid}, 0);
        end
        @(posedge clk); #1 rst_n = 1;
        repeat (3) @(negedge clk);
        check(in_ready, "R1", "in_ready after reset", 32'(in_ready), 1);

        // Scenario 1: free flow, exact latency, video and non-video packets.
        lat_mode = 1;
        send_packet(4'd0, 6, 8'h10);
        send_packet(4'd5, 4, 8'h40);
        idle();
        repeat (8) @(negedge clk);
        lat_mode = 0;

        // Scenario 2: random backpressure, source gaps, offers without ready.
        ordy_mode = 1; gap_mode = 1; junk_mode = 1;
        send_packet(4'd0, 5, 8'h00);
        send(24'h123456, 0, 0);          // stray beat outside a packet (R10)
        send_packet(4'hF, 3, 8'h80);
        send_packet(4'd0, 1, 8'hFF);
        send_packet(4'd3, 0, 8'h00);
        send_packet(4'd0, 7, 8'h21);
        idle();
        ordy_mode = 0;
        repeat (30) @(negedge clk);

        // Scenario 3: long downstream stall in the middle of a packet.
        gap_mode = 0;
        ordy_mode = 2;
        fork
            send_packet(4'd0, 12, 8'h33);
            begin
                repeat (25) @(posedge clk);
                ordy_mode = 0;
            end
        join
        idle();
        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, "R9", "beats still owed at end", 32'(exp_q.size()), 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule